// File: doc/BRIEF.md
# Lockable Multi-Action Watchdog Timer

This block is a per-processor watchdog. Software programs a timeout as a count of timebase ticks (the tick input arrives roughly once per microsecond from a shared prescaler), enables the timer, and must then restart it periodically by writing a fixed key value to the kick port. If the count of ticks since the last restart reaches the programmed period, the watchdog expires and takes exactly one action. That action is one of three: it latches an interrupt, it emits a local processor reset pulse, or it emits a card reset request pulse.

A sticky lock bit protects a watchdog that is armed to reset. Once lock, enable and reset-enable are all set, every later write to the control or period register is discarded until a full reset. The safe programming order is to clear enable, set reset-enable and the action, then enable, and finally lock.

The sequencer has three states. OFF means the timer is disabled. RUN means it is counting ticks down from the period. FIRED means it has expired and its action was taken. The transitions are:
- ENABLE (OFF to RUN) reloads the period.
- KICK (RUN to RUN) reloads the period.
- EXPIRE (RUN to FIRED) happens on the tick that uses up the count.
- REARM (FIRED to RUN) happens on a valid kick and reloads the period.
- DISABLE (RUN or FIRED to OFF) happens when enable is cleared.

Top module: `wd_unit`

## Requirements
- R1: After reset all three outputs are low, the timer is OFF, the lock is clear, and the period register holds its maximum value (all ones).
- R2: The first cycle in which enable is seen set moves the timer to RUN and loads the period. After that, each tick lowers the count. The action fires on the tick seen while the count is 1 or less, so expiry comes on the P-th tick, and a period of 0 behaves like a period of 1.
- R3: A write of the key value (default 32'hA5C3_0F1E) to the kick port in RUN or FIRED reloads the period. A write of any other value has no effect.
- R4: If the interrupt is the selected action, expiry sets the interrupt output in the cycle after the expiring tick. The output stays set until a write-one-to-clear strobe arrives, and a new expiry in the same cycle wins over the clear.
- R5: With reset-enable set (control bit 1) and action code 01 (control bits 3:2), expiry drives the local reset output high for exactly 16 cycles, starting the cycle after the expiring tick.
- R6: With reset-enable set and action code 10, expiry drives the card reset output high for exactly 16 cycles.
- R7: With reset-enable clear, and also with action code 00 or 11, expiry takes the interrupt action.
- R8: The lock (control bit 4) can be set by a control write and is cleared only by reset. While lock, enable (bit 0) and reset-enable are all set, control and period writes are ignored.
- R9: Clearing enable returns the timer to OFF. In OFF, ticks and kicks cause no expiry.
- R10: In FIRED the timer does not fire again until a valid kick rearms it.
- R11: When a valid kick and a tick arrive in the same cycle, the kick wins and the count is reloaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase tick, one cycle wide |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_data_i | input | 5 | Control data: {lock, action[1:0], reset-enable, enable} |
| per_we_i | input | 1 | Period register write strobe |
| per_data_i | input | 24 | Period in ticks |
| kick_we_i | input | 1 | Kick write strobe |
| kick_data_i | input | 32 | Kick data, compared with the key |
| irq_clr_i | input | 1 | Write-one-to-clear for the interrupt |
| irq_o | output | 1 | Latched expiry interrupt |
| loc_rst_o | output | 1 | Local processor reset pulse |
| card_rst_o | output | 1 | Card reset request pulse |

## Verification
A wrong count, a wrong state or a lost configuration bit shows up only at expiry. It appears as an action one cycle early or late, as the wrong output, or as a missing or repeated pulse. The bench therefore compares all three outputs against a behavioural model on every clock. This catches an off-by-one in the countdown within one tick interval of the expected expiry, and it catches a stretched or truncated reset pulse at the 16-cycle boundary. Lock faults show up when a disable attempt is followed by an expiry that should, or should not, happen.

// File: rtl/wd_pkg.sv
package wd_pkg;

    typedef enum logic [1:0] {
        ACT_IRQ   = 2'b00,
        ACT_LOCAL = 2'b01,
        ACT_CARD  = 2'b10,
        ACT_RSVD  = 2'b11
    } wd_act_e;

    typedef enum logic [1:0] {
        ST_OFF   = 2'b00,
        ST_RUN   = 2'b01,
        ST_FIRED = 2'b10
    } wd_state_e;

    typedef struct packed {
        logic    lock;
        wd_act_e act;
        logic    rst_en;
        logic    en;
    } wd_cfg_t;

endpackage

// File: rtl/wd_cfg_regs.sv
module wd_cfg_regs
    import wd_pkg::*;
#(
    parameter int PER_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we_i,
    input  wd_cfg_t          cfg_data_i,
    input  logic             per_we_i,
    input  logic [PER_W-1:0] per_data_i,
    output wd_cfg_t          cfg_o,
    output logic [PER_W-1:0] period_o
);

    logic frozen;
    assign frozen = cfg_o.lock && cfg_o.en && cfg_o.rst_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_o    <= '0;
            period_o <= '1;
        end else begin
            if (cfg_we_i && !frozen) begin
                cfg_o.en     <= cfg_data_i.en;
                cfg_o.rst_en <= cfg_data_i.rst_en;
                cfg_o.act    <= cfg_data_i.act;
                cfg_o.lock   <= cfg_o.lock | cfg_data_i.lock;
            end
            if (per_we_i && !frozen) begin
                period_o <= per_data_i;
            end
        end
    end

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_o.lock |=> cfg_o.lock); // R8
    AST_FROZEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |=> (cfg_o.en && cfg_o.rst_en && $stable(period_o))); // R8

endmodule

// File: rtl/wd_core_fsm.sv
module wd_core_fsm
    import wd_pkg::*;
#(
    parameter int PER_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wd_cfg_t          cfg_i,
    input  logic [PER_W-1:0] period_i,
    input  logic             tick_i,
    input  logic             kick_ok_i,
    output logic             fire_irq_o,
    output logic             fire_loc_o,
    output logic             fire_card_o
);

    wd_state_e        state_q, state_d;
    logic [PER_W-1:0] cnt_q, cnt_d;
    logic             expire;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        expire  = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                if (cfg_i.en) begin
                    state_d = ST_RUN;
                    cnt_d   = period_i;
                end
            end
            ST_RUN: begin
                if (!cfg_i.en) begin
                    state_d = ST_OFF;
                end else if (kick_ok_i) begin
                    cnt_d = period_i;
                end else if (tick_i) begin
                    if (cnt_q <= PER_W'(1)) begin
                        state_d = ST_FIRED;
                        expire  = 1'b1;
                    end else begin
                        cnt_d = cnt_q - PER_W'(1);
                    end
                end
            end
            ST_FIRED: begin
                if (!cfg_i.en) begin
                    state_d = ST_OFF;
                end else if (kick_ok_i) begin
                    state_d = ST_RUN;
                    cnt_d   = period_i;
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        fire_loc_o  = expire && cfg_i.rst_en && (cfg_i.act == ACT_LOCAL);
        fire_card_o = expire && cfg_i.rst_en && (cfg_i.act == ACT_CARD);
        fire_irq_o  = expire && !fire_loc_o && !fire_card_o;
    end

    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fire_irq_o, fire_loc_o, fire_card_o})); // R7
    AST_FIRE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_irq_o || fire_loc_o || fire_card_o) |-> (tick_i && !kick_ok_i)); // R11
    AST_NO_REFIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIRED) |-> !(fire_irq_o || fire_loc_o || fire_card_o)); // R10
    AST_KICK_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i.en && kick_ok_i && state_q != ST_OFF) |=> (cnt_q == $past(period_i))); // R3

endmodule

// File: rtl/wd_pulse_stretch.sv
module wd_pulse_stretch #(
    parameter int PULSE_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic pulse_o
);

    localparam int CW = $clog2(PULSE_LEN + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (trig_i) begin
            cnt_q <= CW'(PULSE_LEN);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign pulse_o = (cnt_q != '0);

    AST_PULSE_DECR: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0 && !trig_i) |=> (cnt_q == $past(cnt_q) - CW'(1))); // R5

endmodule

// File: rtl/wd_unit.sv
module wd_unit
    import wd_pkg::*;
#(
    parameter int          PER_W     = 24,
    parameter int          KEY_W     = 32,
    parameter logic [31:0] KICK_KEY  = 32'hA5C3_0F1E,
    parameter int          PULSE_LEN = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             cfg_we_i,
    input  logic [4:0]       cfg_data_i,
    input  logic             per_we_i,
    input  logic [PER_W-1:0] per_data_i,
    input  logic             kick_we_i,
    input  logic [KEY_W-1:0] kick_data_i,
    input  logic             irq_clr_i,
    output logic             irq_o,
    output logic             loc_rst_o,
    output logic             card_rst_o
);

    localparam int NPULSE = 2;

    wd_cfg_t          cfg;
    logic [PER_W-1:0] period;
    logic             kick_ok;
    logic             fire_irq, fire_loc, fire_card;
    logic [NPULSE-1:0] trig, pulse;

    assign kick_ok = kick_we_i && (kick_data_i == KEY_W'(KICK_KEY));

    wd_cfg_regs #(.PER_W(PER_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we_i   (cfg_we_i),
        .cfg_data_i (wd_cfg_t'(cfg_data_i)),
        .per_we_i   (per_we_i),
        .per_data_i (per_data_i),
        .cfg_o      (cfg),
        .period_o   (period)
    );

    wd_core_fsm #(.PER_W(PER_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_i       (cfg),
        .period_i    (period),
        .tick_i      (tick_i),
        .kick_ok_i   (kick_ok),
        .fire_irq_o  (fire_irq),
        .fire_loc_o  (fire_loc),
        .fire_card_o (fire_card)
    );

    assign trig = {fire_card, fire_loc};

    for (genvar g = 0; g < NPULSE; g++) begin : g_pulse
        wd_pulse_stretch #(.PULSE_LEN(PULSE_LEN)) u_pulse (
            .clk     (clk),
            .rst_n   (rst_n),
            .trig_i  (trig[g]),
            .pulse_o (pulse[g])
        );
    end

    assign loc_rst_o  = pulse[0];
    assign card_rst_o = pulse[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
        end else if (fire_irq) begin
            irq_o <= 1'b1;
        end else if (irq_clr_i) begin
            irq_o <= 1'b0;
        end
    end

    AST_IRQ_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        fire_irq |=> irq_o); // R4
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !irq_clr_i) |=> irq_o); // R4

endmodule

// File: tb/wd_unit_tb.sv
module wd_unit_tb_top;

    localparam logic [31:0] KEY = 32'hA5C3_0F1E;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i;
    logic        cfg_we_i = 1'b0;
    logic [4:0]  cfg_data_i = '0;
    logic        per_we_i = 1'b0;
    logic [23:0] per_data_i = '0;
    logic        kick_we_i = 1'b0;
    logic [31:0] kick_data_i = '0;
    logic        irq_clr_i = 1'b0;
    logic        irq_o, loc_rst_o, card_rst_o;

    logic tick_auto = 1'b0;
    logic tick_force = 1'b0;
    logic tick_en = 1'b0;
    assign tick_i = tick_auto | tick_force;

    int    cyc = 0;
    int    n_vec = 0;
    int    n_bad = 0;
    string cur_req = "R1";

    wd_unit dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .cfg_we_i(cfg_we_i), .cfg_data_i(cfg_data_i),
        .per_we_i(per_we_i), .per_data_i(per_data_i),
        .kick_we_i(kick_we_i), .kick_data_i(kick_data_i),
        .irq_clr_i(irq_clr_i),
        .irq_o(irq_o), .loc_rst_o(loc_rst_o), .card_rst_o(card_rst_o)
    );

    always #10 clk = ~clk;

    // behavioural reference model
    bit m_en = 0, m_re = 0, m_lock = 0;
    int m_act = 0;
    int m_per = 24'hFFFFFF;
    int m_state = 0;          // 0 off, 1 run, 2 fired
    int m_cnt = 0;
    bit m_irq = 0;
    int m_lrem = 0, m_crem = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_re = 0; m_lock = 0; m_act = 0; m_per = 24'hFFFFFF;
            m_state = 0; m_cnt = 0; m_irq = 0; m_lrem = 0; m_crem = 0;
        end else begin
            bit kick_ok, fire, f_loc, f_card, frozen;
            kick_ok = kick_we_i && (kick_data_i == KEY);
            fire = 0;
            case (m_state)
                0: if (m_en) begin m_state = 1; m_cnt = m_per; end
                1: if (!m_en) m_state = 0;
                   else if (kick_ok) m_cnt = m_per;
                   else if (tick_i) begin
                       if (m_cnt <= 1) begin m_state = 2; fire = 1; end
                       else m_cnt = m_cnt - 1;
                   end
                default: if (!m_en) m_state = 0;
                         else if (kick_ok) begin m_state = 1; m_cnt = m_per; end
            endcase
            f_loc  = fire && m_re && m_act == 1;
            f_card = fire && m_re && m_act == 2;
            if (fire && !f_loc && !f_card) m_irq = 1;
            else if (irq_clr_i) m_irq = 0;
            if (f_loc) m_lrem = 16; else if (m_lrem > 0) m_lrem--;
            if (f_card) m_crem = 16; else if (m_crem > 0) m_crem--;
            frozen = m_lock && m_en && m_re;
            if (cfg_we_i && !frozen) begin
                m_en = cfg_data_i[0]; m_re = cfg_data_i[1];
                m_act = int'(cfg_data_i[3:2]);
                m_lock = m_lock | cfg_data_i[4];
            end
            if (per_we_i && !frozen) m_per = int'(per_data_i);
        end
    end

    always @(negedge clk) begin
        cyc++;
        tick_auto = tick_en && (cyc % 4 == 0);
        n_vec++;
        if (irq_o !== m_irq || loc_rst_o !== (m_lrem != 0) || card_rst_o !== (m_crem != 0)) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual irq/loc/card=%b%b%b expected %b%b%b",
                     cur_req, cyc, irq_o, loc_rst_o, card_rst_o,
                     m_irq, (m_lrem != 0), (m_crem != 0));
        end
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL watchdog: actual cycle %0d expected finish by 100000", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_cfg(input bit lock, input bit [1:0] act, input bit re, input bit en);
        @(negedge clk); cfg_we_i = 1; cfg_data_i = {lock, act, re, en};
        @(negedge clk); cfg_we_i = 0;
    endtask

    task automatic wr_per(input int v);
        @(negedge clk); per_we_i = 1; per_data_i = 24'(v);
        @(negedge clk); per_we_i = 0;
    endtask

    task automatic kick(input logic [31:0] v);
        @(negedge clk); kick_we_i = 1; kick_data_i = v;
        @(negedge clk); kick_we_i = 0;
    endtask

    task automatic clr_irq();
        @(negedge clk); irq_clr_i = 1;
        @(negedge clk); irq_clr_i = 0;
    endtask

    initial begin
        // R1: reset state
        cur_req = "R1";
        idle(3);
        @(negedge clk); rst_n = 1;
        idle(3);
        tick_en = 1;
        // R2: countdown and interrupt expiry, period 3
        cur_req = "R2";
        wr_per(3);
        wr_cfg(0, 2'b00, 0, 1);
        idle(20);
        // R4: latched until cleared
        cur_req = "R4";
        idle(6);
        clr_irq();
        // R10: no refire in expired state
        cur_req = "R10";
        idle(30);
        // R3: key kicks hold off expiry, wrong key does not
        cur_req = "R3";
        kick(KEY);
        for (int i = 0; i < 5; i++) begin idle(5); kick(KEY); end
        for (int i = 0; i < 4; i++) begin idle(2); kick(32'h1234_5678); end
        idle(10);
        clr_irq();
        // R2: period 0 acts as 1
        cur_req = "R2";
        wr_cfg(0, 2'b00, 0, 0);
        wr_per(0);
        wr_cfg(0, 2'b00, 0, 1);
        idle(10);
        clr_irq();
        // R9: disabled timer ignores ticks and kicks
        cur_req = "R9";
        wr_cfg(0, 2'b00, 0, 0);
        kick(KEY);
        idle(40);
        // R5: local reset pulse
        cur_req = "R5";
        wr_per(2);
        wr_cfg(0, 2'b01, 1, 0);
        wr_cfg(0, 2'b01, 1, 1);
        idle(30);
        // R6: card reset pulse
        cur_req = "R6";
        wr_cfg(0, 2'b10, 1, 0);
        wr_cfg(0, 2'b10, 1, 1);
        idle(30);
        // R7: reset-enable clear or action 11 gives interrupt
        cur_req = "R7";
        wr_cfg(0, 2'b10, 0, 0);
        wr_cfg(0, 2'b10, 0, 1);
        idle(16);
        clr_irq();
        wr_cfg(0, 2'b11, 1, 0);
        wr_cfg(0, 2'b11, 1, 1);
        idle(16);
        clr_irq();
        // R11: kick coincident with tick wins
        cur_req = "R11";
        wr_cfg(0, 2'b00, 0, 0);
        tick_en = 0;
        wr_per(1);
        wr_cfg(0, 2'b00, 0, 1);
        idle(2);
        @(negedge clk); tick_force = 1; kick_we_i = 1; kick_data_i = KEY;
        @(negedge clk); tick_force = 0; kick_we_i = 0;
        idle(3);
        @(negedge clk); tick_force = 1;
        @(negedge clk); tick_force = 0;
        idle(3);
        clr_irq();
        // R8: locked armed timer ignores disable and period writes
        cur_req = "R8";
        tick_en = 1;
        wr_cfg(0, 2'b01, 1, 0);
        wr_per(6);
        wr_cfg(1, 2'b01, 1, 1);
        wr_cfg(0, 2'b00, 0, 0);
        wr_per(1000);
        idle(40);
        kick(KEY);
        wr_cfg(0, 2'b00, 0, 0);
        idle(40);
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule